// File: doc/BRIEF.md
# Serial Flash Transaction Engine

This block runs one serial flash transaction at a time on a single-lane SPI bus in mode 0. Each transaction is described by a small set of fields presented with a start pulse: a transaction kind (command only, write or read), a one-byte opcode, an enable for a 24-bit address phase, the address itself and a data byte count. The engine lowers chip select and shifts out the opcode. It then sends the address if enabled, then streams the data phase. It releases chip select and raises a done flag that software polls.

Write data is loaded ahead of time, or during the transaction, into a word-wide transmit FIFO. Each 32-bit word is sent most significant byte first. Read data is packed into a 32-bit status word that the host reads once done is set. The serial clock runs at half the core clock. Every bit occupies one low and one high core cycle. One extra low cycle separates the opcode, address and each data word.

Top module: `sfl_xact_engine`

## Requirements
- R1: After reset cs_no is 1, sck_o is 0, busy_o and done_o are 0, rdata_o is 0 and fifo_full_o is 0.
- R2: A start_i pulse while idle is accepted: busy_o rises and done_o clears on the next cycle. cs_no stays low for every sck_o pulse of the transaction. A start_i pulse while busy_o is 1 has no effect and produces no extra frame.
- R3: The first 8 bits of every frame are opcode_i, MSB first.
- R4: When addr_en_i is 1, the 24 bits of addr_i follow the opcode, MSB first. When it is 0, no address bits are sent.
- R5: kind_i encoding: 0 is command only, 1 is write, 2 is read, and 3 behaves as 0. A command-only frame has no data phase whatever byte_cnt_i holds.
- R6: A write sends exactly byte_cnt_i bytes taken from FIFO words, each word most significant byte (bits 31:24) first. A partially used last word is discarded.
- R7: If a write needs a word while the FIFO is empty, the engine waits with cs_no low and sck_o low, and resumes when a word is pushed.
- R8: Every transaction clears rdata_o when it starts. A read of N ≤ 4 bytes puts byte k (k = 0 first) in bits 31-8k down to 24-8k, and the unused low bytes stay 0. A read or write with byte_cnt_i = 0 has no data phase.
- R9: A read longer than 4 bytes leaves the last 4 received bytes in rdata_o, the oldest of them in bits 31:24.
- R10: done_o rises in the cycle cs_no returns high and stays set, with rdata_o unchanged, until the next accepted start.
- R11: fifo_full_o is 1 when FIFO_DEPTH words are held, and a push while full is dropped. fifo_clr_i empties the FIFO and takes priority over a push in the same cycle.
- R12: mosi_o changes only while sck_o is low. miso_i is sampled as sck_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, taken only when idle |
| kind_i | input | 2 | Transaction kind: 0 command, 1 write, 2 read |
| opcode_i | input | 8 | Opcode byte |
| addr_en_i | input | 1 | Enables the 24-bit address phase |
| addr_i | input | 24 | Address value |
| byte_cnt_i | input | CNT_W | Data phase length in bytes |
| fifo_clr_i | input | 1 | Empties the transmit FIFO |
| fifo_wr_i | input | 1 | Pushes fifo_wdata_i |
| fifo_wdata_i | input | 32 | Transmit word |
| fifo_full_o | output | 1 | FIFO holds FIFO_DEPTH words |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Last transaction complete |
| rdata_o | output | 32 | Packed read data |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The hardest state to reach is the mid-frame underrun stall. The engine must sit in the middle of a write with chip select low, the clock parked low and exactly the bits of the already-drained words on the wire. To get there, the bench fills the FIFO to its depth and then tries one more push, which must be dropped. It launches a write one word longer than what was accepted and waits until the slave model has counted exactly those bits. It then holds off for many cycles before supplying the missing word, so that the resumed frame must carry that word and not the dropped one.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [1:0] {
    KIND_CMD = 2'd0,
    KIND_WR  = 2'd1,
    KIND_RD  = 2'd2,
    KIND_RSV = 2'd3
  } kind_e;

  typedef enum logic [1:0] {SEG_OPC, SEG_ADR, SEG_DAT} seg_e;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_NEXT, ST_HOLD} st_e;

  localparam int unsigned OPC_BITS  = 8;
  localparam int unsigned ADR_BITS  = 24;
  localparam int unsigned WORD_BITS = 32;
endpackage

// File: rtl/sfl_tx_fifo.sv
module sfl_tx_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o && !clr_i;
  assign pop_ok  = pop_i && !empty_o && !clr_i;
  assign rdata_o = mem_q[rptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= nxt(wptr_q);
      if (pop_ok)  rptr_q <= nxt(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sfl_rx_pack.sv
module sfl_rx_pack (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        bit_vld_i,
  input  logic        bit_i,
  output logic [31:0] word_o
);
  logic [6:0]  sr_q;
  logic [2:0]  bcnt_q;
  logic [2:0]  lane_q;
  logic [31:0] word_q;
  logic [7:0]  byte_w;

  assign byte_w = {sr_q, bit_i};
  assign word_o = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      bcnt_q <= '0;
      lane_q <= '0;
      word_q <= '0;
    end else if (clr_i) begin
      sr_q   <= '0;
      bcnt_q <= '0;
      lane_q <= '0;
      word_q <= '0;
    end else if (bit_vld_i) begin
      sr_q   <= byte_w[6:0];
      bcnt_q <= bcnt_q + 3'd1;
      if (bcnt_q == 3'd7) begin
        if (lane_q < 3'd4) begin
          // fill lanes from the top until the word is full
          for (int k = 0; k < 4; k++) begin
            if (lane_q == 3'(k)) word_q[8*(3-k) +: 8] <= byte_w;
          end
          lane_q <= lane_q + 3'd1;
        end else begin
          word_q <= {word_q[23:0], byte_w};
        end
      end
    end
  end
endmodule

// File: rtl/sfl_seq.sv
module sfl_seq
  import sfl_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [1:0]           kind_i,
  input  logic [7:0]           opcode_i,
  input  logic                 addr_en_i,
  input  logic [23:0]          addr_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 fifo_empty_i,
  input  logic [WORD_BITS-1:0] fifo_word_i,
  output logic                 fifo_pop_o,
  output logic                 rx_clr_o,
  output logic                 rx_vld_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 sck_o,
  output logic                 cs_no,
  output logic                 mosi_o
);
  localparam int unsigned DB_W = CNT_W + 3;
  localparam int unsigned SB_W = $clog2(WORD_BITS) + 1;

  st_e                  st_q;
  seg_e                 seg_q;
  kind_e                kind_q;
  logic                 half_q;
  logic [WORD_BITS-1:0] sr_q;
  logic [SB_W-1:0]      sbits_q;
  logic [DB_W-1:0]      dleft_q;
  logic                 aen_q;
  logic [ADR_BITS-1:0]  adr_q;
  logic                 sck_q, csn_q, done_q;

  logic            accept, need_adr, has_data, data_kind;
  logic [SB_W-1:0] chunk;

  assign accept    = start_i && (st_q == ST_IDLE);
  assign need_adr  = (seg_q == SEG_OPC) && aen_q;
  assign has_data  = (dleft_q != '0);
  assign data_kind = (kind_i == KIND_WR) || (kind_i == KIND_RD);
  assign chunk     = (dleft_q >= DB_W'(WORD_BITS)) ? SB_W'(WORD_BITS) : SB_W'(dleft_q);

  assign fifo_pop_o = (st_q == ST_NEXT) && !need_adr && has_data &&
                      (kind_q == KIND_WR) && !fifo_empty_i;
  assign rx_clr_o   = accept;
  assign rx_vld_o   = (st_q == ST_SHIFT) && !half_q && (seg_q == SEG_DAT) &&
                      (kind_q == KIND_RD);

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign sck_o  = sck_q;
  assign cs_no  = csn_q;
  assign mosi_o = sr_q[WORD_BITS-1] & ~csn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      seg_q   <= SEG_OPC;
      kind_q  <= KIND_CMD;
      half_q  <= 1'b0;
      sr_q    <= '0;
      sbits_q <= '0;
      dleft_q <= '0;
      aen_q   <= 1'b0;
      adr_q   <= '0;
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            kind_q  <= kind_e'(kind_i);
            aen_q   <= addr_en_i;
            adr_q   <= addr_i;
            dleft_q <= data_kind ? {cnt_i, 3'b000} : '0;
            sr_q    <= {opcode_i, {(WORD_BITS-OPC_BITS){1'b0}}};
            sbits_q <= SB_W'(OPC_BITS);
            seg_q   <= SEG_OPC;
            half_q  <= 1'b0;
            csn_q   <= 1'b0;
            done_q  <= 1'b0;
            st_q    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (!half_q) begin
            sck_q  <= 1'b1;
            half_q <= 1'b1;
          end else begin
            sck_q   <= 1'b0;
            half_q  <= 1'b0;
            sr_q    <= sr_q << 1;
            sbits_q <= sbits_q - SB_W'(1);
            if (seg_q == SEG_DAT) dleft_q <= dleft_q - DB_W'(1);
            if (sbits_q == SB_W'(1)) st_q <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (need_adr) begin
            sr_q    <= {adr_q, {(WORD_BITS-ADR_BITS){1'b0}}};
            sbits_q <= SB_W'(ADR_BITS);
            seg_q   <= SEG_ADR;
            st_q    <= ST_SHIFT;
          end else if (has_data) begin
            if (kind_q == KIND_RD) begin
              sr_q    <= '0;
              sbits_q <= chunk;
              seg_q   <= SEG_DAT;
              st_q    <= ST_SHIFT;
            end else if (!fifo_empty_i) begin
              sr_q    <= fifo_word_i;
              sbits_q <= chunk;
              seg_q   <= SEG_DAT;
              st_q    <= ST_SHIFT;
            end
            // empty FIFO on a write: park with clock low
          end else begin
            st_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          csn_q  <= 1'b1;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfl_xact_engine.sv
module sfl_xact_engine
  import sfl_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned CNT_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       kind_i,
  input  logic [7:0]       opcode_i,
  input  logic             addr_en_i,
  input  logic [23:0]      addr_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             fifo_clr_i,
  input  logic             fifo_wr_i,
  input  logic [31:0]      fifo_wdata_i,
  output logic             fifo_full_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [31:0]      rdata_o,
  output logic             sck_o,
  output logic             cs_no,
  output logic             mosi_o,
  input  logic             miso_i
);
  logic                 fifo_empty, fifo_pop;
  logic [WORD_BITS-1:0] fifo_word;
  logic                 rx_clr, rx_vld;

  sfl_tx_fifo #(
    .DEPTH (FIFO_DEPTH),
    .W     (WORD_BITS)
  ) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fifo_clr_i),
    .push_i  (fifo_wr_i),
    .wdata_i (fifo_wdata_i),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_word),
    .full_o  (fifo_full_o),
    .empty_o (fifo_empty)
  );

  sfl_seq #(
    .CNT_W (CNT_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .kind_i       (kind_i),
    .opcode_i     (opcode_i),
    .addr_en_i    (addr_en_i),
    .addr_i       (addr_i),
    .cnt_i        (byte_cnt_i),
    .fifo_empty_i (fifo_empty),
    .fifo_word_i  (fifo_word),
    .fifo_pop_o   (fifo_pop),
    .rx_clr_o     (rx_clr),
    .rx_vld_o     (rx_vld),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .sck_o        (sck_o),
    .cs_no        (cs_no),
    .mosi_o       (mosi_o)
  );

  sfl_rx_pack u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (rx_clr),
    .bit_vld_i (rx_vld),
    .bit_i     (miso_i),
    .word_o    (rdata_o)
  );
endmodule

// File: rtl/sfl_xact_engine_chk.sv
module sfl_xact_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        fifo_clr_i,
  input logic        fifo_wr_i,
  input logic        fifo_full_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] rdata_o,
  input logic        sck_o,
  input logic        cs_no,
  input logic        mosi_o
);
  p_idle_cs_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);

  p_sck_in_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);

  p_start_clears_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o));

  p_done_on_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $rose(cs_no));

  p_done_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  p_rdata_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(rdata_o));

  p_mosi_stable_high_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(mosi_o));

  p_full_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full_o && fifo_wr_i && !fifo_clr_i && !busy_o) |=> fifo_full_o);

  p_clear_empties_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> !fifo_full_o);
endmodule

bind sfl_xact_engine sfl_xact_engine_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .fifo_clr_i  (fifo_clr_i),
  .fifo_wr_i   (fifo_wr_i),
  .fifo_full_o (fifo_full_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rdata_o     (rdata_o),
  .sck_o       (sck_o),
  .cs_no       (cs_no),
  .mosi_o      (mosi_o)
);

// File: tb/tb_sfl_xact_engine.sv
module tb_sfl_xact_engine;
  localparam int unsigned CNT_W = 10;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [1:0]       kind_i = '0;
  logic [7:0]       opcode_i = '0;
  logic             addr_en_i = 1'b0;
  logic [23:0]      addr_i = '0;
  logic [CNT_W-1:0] byte_cnt_i = '0;
  logic             fifo_clr_i = 1'b0;
  logic             fifo_wr_i = 1'b0;
  logic [31:0]      fifo_wdata_i = '0;
  logic             fifo_full_o, busy_o, done_o, sck_o, cs_no, mosi_o;
  logic [31:0]      rdata_o;
  logic             miso_i = 1'b0;

  always #10 clk_i = ~clk_i;

  sfl_xact_engine #(.FIFO_DEPTH(8), .CNT_W(CNT_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .kind_i(kind_i),
    .opcode_i(opcode_i), .addr_en_i(addr_en_i), .addr_i(addr_i),
    .byte_cnt_i(byte_cnt_i), .fifo_clr_i(fifo_clr_i), .fifo_wr_i(fifo_wr_i),
    .fifo_wdata_i(fifo_wdata_i), .fifo_full_o(fifo_full_o), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .sck_o(sck_o), .cs_no(cs_no),
    .mosi_o(mosi_o), .miso_i(miso_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  int viol = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;

  logic [7:0]  dbytes[$];
  bit          exp_bits[$];
  int          exp_len[$];
  logic [31:0] exp_rd[$];
  string       exp_tag[$];
  bit          cap[$];
  bit          resp[$];
  int          ridx = 0;
  logic        last_rise = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // slave model, mode 0
  always @(posedge sck_o) begin
    cap.push_back(mosi_o);
    last_rise = mosi_o;
  end

  always @(negedge sck_o) begin
    ridx++;
    miso_i = (ridx < resp.size()) ? resp[ridx] : 1'b0;
  end

  always @(negedge clk_i) begin
    if (mon_en && sck_o === 1'b1 && mosi_o !== last_rise) viol++;
  end

  // monitor: pops scoreboard items at each frame end
  always @(posedge cs_no) begin
    if (mon_en) begin
      @(negedge clk_i);
      if (exp_len.size() == 0) begin
        chk(1'b0, "R2", "unexpected frame", 32'(cap.size()), 32'd0);
      end else begin
        int len;
        int bad;
        string tag;
        logic [31:0] er;
        len = exp_len.pop_front();
        er  = exp_rd.pop_front();
        tag = exp_tag.pop_front();
        bad = 0;
        for (int i = 0; i < len; i++) begin
          bit e;
          e = exp_bits.pop_front();
          if (i >= cap.size() || cap[i] != e) bad++;
        end
        chk(bad == 0 && cap.size() == len, tag, "frame bits (len,mismatch)",
            {16'(cap.size()), 16'(bad)}, {16'(len), 16'd0});
        chk(rdata_o == er, tag, "status word", rdata_o, er);
      end
    end
  end

  task automatic push_word(input logic [31:0] w);
    @(negedge clk_i);
    fifo_wr_i = 1'b1;
    fifo_wdata_i = w;
    @(negedge clk_i);
    fifo_wr_i = 1'b0;
  endtask

  task automatic xact(input logic [1:0] k, input logic [7:0] op, input logic ae,
                      input logic [23:0] ad, input int cnt, input string tag);
    bit dat;
    int hdr;
    logic [31:0] er;
    dat = (k == 2'd1 || k == 2'd2) && cnt > 0;
    hdr = 8 + (ae ? 24 : 0);
    exp_len.push_back(hdr + (dat ? cnt * 8 : 0));
    for (int b = 7; b >= 0; b--) exp_bits.push_back(op[b]);
    if (ae) for (int b = 23; b >= 0; b--) exp_bits.push_back(ad[b]);
    if (dat) begin
      for (int j = 0; j < cnt; j++)
        for (int b = 7; b >= 0; b--)
          exp_bits.push_back(k == 2'd1 ? dbytes[j][b] : 1'b0);
    end
    er = '0;
    if (k == 2'd2) begin
      for (int j = 0; j < cnt; j++) begin
        if (j < 4) er[8*(3-j) +: 8] = dbytes[j];
        else er = {er[23:0], dbytes[j]};
      end
    end
    exp_rd.push_back(er);
    exp_tag.push_back(tag);
    resp.delete();
    for (int i = 0; i < hdr; i++) resp.push_back(1'b0);
    if (k == 2'd2) begin
      for (int j = 0; j < cnt; j++)
        for (int b = 7; b >= 0; b--) resp.push_back(dbytes[j][b]);
    end
    ridx = 0;
    miso_i = (resp.size() > 0) ? resp[0] : 1'b0;
    cap.delete();
    @(negedge clk_i);
    kind_i = k;
    opcode_i = op;
    addr_en_i = ae;
    addr_i = ad;
    byte_cnt_i = CNT_W'(cnt);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic bytes_of(input logic [31:0] w);
    dbytes.push_back(w[31:24]);
    dbytes.push_back(w[23:16]);
    dbytes.push_back(w[15:8]);
    dbytes.push_back(w[7:0]);
  endtask

  function automatic logic [31:0] big_word(input int i);
    return {8'(i), ~8'(i), 8'(i) ^ 8'h5A, 8'hC3};
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(cs_no == 1'b1 && sck_o == 1'b0, "R1", "cs/sck", {30'd0, cs_no, sck_o}, 32'd2);
    chk(!busy_o && !done_o && !fifo_full_o, "R1", "busy/done/full",
        {29'd0, busy_o, done_o, fifo_full_o}, 32'd0);
    chk(rdata_o == 32'd0, "R1", "status word", rdata_o, 32'd0);
    mon_en = 1'b1;

    // R3 / R5 command only, count ignored
    dbytes.delete();
    xact(2'd0, 8'h06, 1'b0, 24'h0, 5, "R3");
    chk(done_o == 1'b1, "R10", "done after frame", {31'd0, done_o}, 32'd1);
    xact(2'd3, 8'hA7, 1'b0, 24'h0, 2, "R5");
    // R4 address phase
    xact(2'd0, 8'h13, 1'b1, 24'h8A5C3E, 0, "R4");

    // R8 reads of 1, 3, 4 bytes
    dbytes = '{8'hA5};
    xact(2'd2, 8'h0F, 1'b1, 24'hC00000, 1, "R8");
    dbytes = '{8'h12, 8'h34, 8'h56};
    xact(2'd2, 8'h03, 1'b1, 24'h000100, 3, "R8");
    dbytes = '{8'h11, 8'h22, 8'h33, 8'h44};
    xact(2'd2, 8'h03, 1'b0, 24'h0, 4, "R8");
    // R8 zero count read clears status
    dbytes.delete();
    xact(2'd2, 8'h0B, 1'b1, 24'h123456, 0, "R8");

    // R9 long reads keep the last four bytes
    dbytes = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    xact(2'd2, 8'h03, 1'b1, 24'h000004, 6, "R9");
    repeat (25) @(negedge clk_i);
    chk(done_o && rdata_o == 32'h03040506, "R10", "status held while idle",
        rdata_o, 32'h03040506);
    dbytes = '{8'h91, 8'h92, 8'h93, 8'h94, 8'h95, 8'h96, 8'h97, 8'h98, 8'h99};
    xact(2'd2, 8'h03, 1'b0, 24'h0, 9, "R9");

    // R6 partial final word discarded
    push_word(32'hDEADBEEF);
    push_word(32'hCAFE1234);
    dbytes = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'hCA, 8'hFE};
    xact(2'd1, 8'h84, 1'b0, 24'h0, 6, "R6");
    push_word(32'h0BADF00D);
    dbytes = '{8'h0B, 8'hAD, 8'hF0, 8'h0D};
    xact(2'd1, 8'h02, 1'b1, 24'h000010, 4, "R6");

    // R11 full, then R7 stall mid write
    dbytes.delete();
    for (int i = 0; i < 8; i++) begin
      push_word(32'h10203040 + 32'(i));
      bytes_of(32'h10203040 + 32'(i));
    end
    @(negedge clk_i);
    chk(fifo_full_o == 1'b1, "R11", "full at depth", {31'd0, fifo_full_o}, 32'd1);
    push_word(32'hBADBAD00);
    bytes_of(32'h5A5A5A5A);
    fork
      xact(2'd1, 8'h84, 1'b0, 24'h0, 36, "R7");
      begin
        repeat (5) @(negedge clk_i);
        while (cap.size() < 264) @(negedge clk_i);
        repeat (20) @(negedge clk_i);
        chk(cap.size() == 264, "R7", "bits before stall", 32'(cap.size()), 32'd264);
        chk(busy_o && !cs_no && !sck_o, "R7", "stalled busy/cs/sck",
            {29'd0, busy_o, cs_no, sck_o}, 32'd4);
        push_word(32'h5A5A5A5A);
      end
    join

    // R11 clear wins over simultaneous push
    push_word(32'h11111111);
    push_word(32'h22222222);
    @(negedge clk_i);
    fifo_clr_i = 1'b1;
    fifo_wr_i = 1'b1;
    fifo_wdata_i = 32'h33333333;
    @(negedge clk_i);
    fifo_clr_i = 1'b0;
    fifo_wr_i = 1'b0;
    chk(fifo_full_o == 1'b0, "R11", "not full after clear", {31'd0, fifo_full_o}, 32'd0);
    push_word(32'h44444444);
    dbytes = '{8'h44, 8'h44, 8'h44, 8'h44};
    xact(2'd1, 8'h02, 1'b1, 24'h000800, 4, "R11");

    // R2 start while busy ignored
    dbytes.delete();
    fork
      xact(2'd0, 8'hD8, 1'b1, 24'h000140, 0, "R2");
      begin
        repeat (8) @(negedge clk_i);
        kind_i = 2'd2;
        byte_cnt_i = CNT_W'(4);
        addr_en_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
      end
    join
    repeat (20) @(negedge clk_i);
    chk(!busy_o && cs_no && exp_len.size() == 0, "R2", "no second frame",
        {30'd0, busy_o, cs_no}, 32'd1);

    // R6 long write fed while running
    dbytes.delete();
    for (int i = 0; i < 128; i++) bytes_of(big_word(i));
    fork
      xact(2'd1, 8'h84, 1'b1, 24'h020000, 512, "R6");
      begin
        for (int i = 0; i < 128; i++) begin
          while (fifo_full_o) @(negedge clk_i);
          push_word(big_word(i));
        end
      end
    join

    chk(viol == 0, "R12", "mosi changed while sck high", 32'(viol), 32'd0);
    chk(exp_len.size() == 0, "R2", "frames outstanding", 32'(exp_len.size()), 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule